// File: doc/BRIEF.md
# Host Port Request and Flag Control

This block holds the host-side control register of a parallel host-to-processor port. It drives the one request line that the port presents to the host. The host programs a receive enable, a transmit enable, two general-purpose flags and a two-bit transfer mode. The block combines the enables and the mode with two status inputs from the port's data path, "receive data full" and "transmit data empty". From them it produces an active-low, registered request to the host.

With the mode field at zero, the request line acts as an interrupt: it is the OR of the enabled status conditions. Any non-zero mode turns the same line into a DMA request, and the enables then choose the direction of the transfer. Programming both enables in DMA mode is not a legal setting. In that case the line stays quiet and a sticky error bit is raised.

The two host flags let the host signal the processor. They are mirrored into a processor-side status word, which the processor can read but cannot change. Four reset sources clear the register: hardware, software, individual port and stop-mode.

Top module: `hostreq_ctrl`

## Requirements
- R1: While `rst` is high and after it falls, `host_rdata` reads 0x00, `req_n` is 1, `cfg_err` is 0 and `cpu_status` is 0x00.
- R2: Control register layout: bit 0 is the receive enable, bit 1 the transmit enable, bit 3 host flag 0, bit 4 host flag 1, and bits 6:5 the mode. A host write is readable on `host_rdata` from the cycle after the write, equal to the written value ANDed with 0x7B.
- R3: Bits 2 and 7 of `host_rdata` always read 0, whatever was written to them.
- R4: With mode 00 and both enables 0, `req_n` stays 1 for every value of `rx_full` and `tx_empty`.
- R5: With mode 00, `req_n` is low exactly when (receive enable AND `rx_full`) OR (transmit enable AND `tx_empty`).
- R6: With a non-zero mode: enables 00 keep `req_n` at 1; receive enable alone makes `req_n` low exactly when `rx_full` is 1 (processor-to-host transfer); transmit enable alone makes `req_n` low exactly when `tx_empty` is 1 (host-to-processor transfer).
- R7: With a non-zero mode and both enables set, `req_n` is held at 1 and `cfg_err` goes to 1 one clock later. `cfg_err` then stays 1 until one of the four resets.
- R8: `req_n` is registered: it changes on the first rising clock edge after a change of control or status, never in the same cycle.
- R9: `cpu_wr` and `cpu_wdata` have no effect on the host flags, as seen on `cpu_status` and `host_rdata`.
- R10: A one-cycle pulse on `sw_rst`, `port_rst` or `stop_rst` clears the whole control register, both flags included, so that `host_rdata` and `cpu_status` read 0x00.
- R11: `cpu_status` bit 3 carries host flag 0 and bit 4 carries host flag 1. Every other bit of `cpu_status` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Hardware reset, synchronous, active high |
| sw_rst | input | 1 | Software reset, synchronous, active high |
| port_rst | input | 1 | Individual port reset, synchronous, active high |
| stop_rst | input | 1 | Stop-mode reset, synchronous, active high |
| host_wr | input | 1 | Host write strobe for the control register |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Control register readback |
| cpu_wr | input | 1 | Processor write strobe to the status word (ignored for the flags) |
| cpu_wdata | input | 8 | Processor write data |
| cpu_status | output | 8 | Processor-side status word with the mirrored flags |
| rx_full | input | 1 | Receive data register full |
| tx_empty | input | 1 | Transmit data register empty |
| req_n | output | 1 | Active-low request to the host, registered |
| cfg_err | output | 1 | Sticky flag for the illegal DMA setting |

## Verification
The stimulus table crosses each enable pattern with status inputs that should and should not raise the request, in both interrupt and DMA modes. Swapping the receive and transmit roles, or treating DMA like interrupt mode, therefore lowers `req_n` in a row that expects it high. The illegal DMA setting is driven with both status inputs active, then followed by a legal setting. A design that lets the request through, or clears the error bit without a reset, is caught. The bench also samples `req_n` in the same cycle as a status change to catch a combinational path. It drives processor writes and each soft reset separately, to catch flags that the processor can alter or that one reset source fails to clear.

// File: rtl/hostreq_pkg.sv
package hostreq_pkg;

    localparam int REG_W     = 8;
    localparam int RXE_B     = 0;
    localparam int TXE_B     = 1;
    localparam int RSV_B     = 2;
    localparam int HF0_B     = 3;
    localparam int HF1_B     = 4;
    localparam int MODE_LO_B = 5;
    localparam int MODE_W    = 2;
    localparam int PAD_B     = 7;
    localparam int ST_HF0_B  = 3;
    localparam int ST_HF1_B  = 4;

    localparam logic [REG_W-1:0] RD_MASK =
        REG_W'((1 << RXE_B) | (1 << TXE_B) | (1 << HF0_B) | (1 << HF1_B) |
               (((1 << MODE_W) - 1) << MODE_LO_B));

    typedef enum logic [MODE_W-1:0] {
        MODE_IRQ  = 2'b00,
        MODE_DMA1 = 2'b01,
        MODE_DMA2 = 2'b10,
        MODE_DMA3 = 2'b11
    } xfer_mode_e;

    typedef enum logic [1:0] {
        DIR_NONE = 2'b00,
        DIR_RX   = 2'b01,
        DIR_TX   = 2'b10,
        DIR_BAD  = 2'b11
    } dma_dir_e;

    typedef struct packed {
        xfer_mode_e mode;
        logic       hf1;
        logic       hf0;
        logic       tx_en;
        logic       rx_en;
    } ctrl_t;

    function automatic ctrl_t ctrl_from_word(input logic [REG_W-1:0] w);
        ctrl_t c;
        c.mode  = xfer_mode_e'(w[MODE_LO_B +: MODE_W]);
        c.hf1   = w[HF1_B];
        c.hf0   = w[HF0_B];
        c.tx_en = w[TXE_B];
        c.rx_en = w[RXE_B];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [REG_W-1:0] w;
        w                        = '0;
        w[RXE_B]                 = c.rx_en;
        w[TXE_B]                 = c.tx_en;
        w[HF0_B]                 = c.hf0;
        w[HF1_B]                 = c.hf1;
        w[MODE_LO_B +: MODE_W]   = c.mode;
        return w;
    endfunction

    function automatic dma_dir_e dma_dir(input ctrl_t c);
        return dma_dir_e'({c.tx_en, c.rx_en});
    endfunction

    function automatic logic irq_level(input ctrl_t c, input logic rxf, input logic txe);
        return (c.rx_en & rxf) | (c.tx_en & txe);
    endfunction

endpackage

// File: rtl/hostreq_ctrl_reg.sv
module hostreq_ctrl_reg
    import hostreq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_soft,
    input  logic             host_wr,
    input  logic [REG_W-1:0] host_wdata,
    output ctrl_t            ctrl_q,
    output logic [REG_W-1:0] host_rdata
);

    always_ff @(posedge clk) begin
        if (rst || clr_soft) begin
            ctrl_q <= '0;
        end else if (host_wr) begin
            ctrl_q <= ctrl_from_word(host_wdata);
        end
    end

    always_comb begin
        host_rdata = ctrl_to_word(ctrl_q);
    end

    AST_READBACK: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !clr_soft) |=> (host_rdata == ($past(host_wdata) & RD_MASK))); // R2

    AST_FLAGS_HOST_ONLY: assert property (@(posedge clk) disable iff (rst)
        (!host_wr && !clr_soft) |=> $stable({ctrl_q.hf1, ctrl_q.hf0})); // R9

    AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clr_soft |=> (host_rdata == '0)); // R10

endmodule

// File: rtl/hostreq_req_gen.sv
module hostreq_req_gen
    import hostreq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr_soft,
    input  ctrl_t ctrl,
    input  logic  rx_full,
    input  logic  tx_empty,
    output logic  req_n_q,
    output logic  err_q
);

    dma_dir_e dir;
    logic     dma_on;
    logic     want;
    logic     bad;

    always_comb begin
        dir    = dma_dir(ctrl);
        dma_on = (ctrl.mode != MODE_IRQ);
        bad    = dma_on && (dir == DIR_BAD);
        if (!dma_on) begin
            want = irq_level(ctrl, rx_full, tx_empty);
        end else begin
            unique case (dir)
                DIR_RX:  want = rx_full;
                DIR_TX:  want = tx_empty;
                default: want = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr_soft) begin
            req_n_q <= 1'b1;
            err_q   <= 1'b0;
        end else begin
            req_n_q <= ~want;
            if (bad) begin
                err_q <= 1'b1;
            end
        end
    end

    AST_POLL_QUIET: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == MODE_IRQ && !ctrl.rx_en && !ctrl.tx_en) |=> req_n_q); // R4

    AST_DMA_RX: assert property (@(posedge clk) disable iff (rst)
        (!clr_soft && ctrl.mode != MODE_IRQ && ctrl.rx_en && !ctrl.tx_en && rx_full) |=> !req_n_q); // R6

    AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!clr_soft && ctrl.mode != MODE_IRQ && ctrl.rx_en && ctrl.tx_en) |=> (req_n_q && err_q)); // R7

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err_q && !clr_soft) |=> err_q); // R7

endmodule

// File: rtl/hostreq_flag_mirror.sv
module hostreq_flag_mirror
    import hostreq_pkg::*;
(
    input  ctrl_t            ctrl,
    output logic [REG_W-1:0] cpu_status
);

    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (i == ST_HF0_B) begin : g_hf0
            assign cpu_status[i] = ctrl.hf0;
        end else if (i == ST_HF1_B) begin : g_hf1
            assign cpu_status[i] = ctrl.hf1;
        end else begin : g_zero
            assign cpu_status[i] = 1'b0;
        end
    end

endmodule

// File: rtl/hostreq_ctrl.sv
module hostreq_ctrl
    import hostreq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_rst,
    input  logic             port_rst,
    input  logic             stop_rst,
    input  logic             host_wr,
    input  logic [REG_W-1:0] host_wdata,
    output logic [REG_W-1:0] host_rdata,
    input  logic             cpu_wr,
    input  logic [REG_W-1:0] cpu_wdata,
    output logic [REG_W-1:0] cpu_status,
    input  logic             rx_full,
    input  logic             tx_empty,
    output logic             req_n,
    output logic             cfg_err
);

    logic  clr_soft;
    ctrl_t ctrl_q;

    assign clr_soft = sw_rst | port_rst | stop_rst;

    hostreq_ctrl_reg u_reg (
        .clk        (clk),
        .rst        (rst),
        .clr_soft   (clr_soft),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .ctrl_q     (ctrl_q),
        .host_rdata (host_rdata)
    );

    hostreq_req_gen u_req (
        .clk      (clk),
        .rst      (rst),
        .clr_soft (clr_soft),
        .ctrl     (ctrl_q),
        .rx_full  (rx_full),
        .tx_empty (tx_empty),
        .req_n_q  (req_n),
        .err_q    (cfg_err)
    );

    hostreq_flag_mirror u_mir (
        .ctrl       (ctrl_q),
        .cpu_status (cpu_status)
    );

    AST_MIRROR_HF: assert property (@(posedge clk) disable iff (rst)
        (cpu_status[ST_HF0_B] == host_rdata[HF0_B]) &&
        (cpu_status[ST_HF1_B] == host_rdata[HF1_B])); // R11

    AST_CPU_NOWRITE: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && !host_wr && !clr_soft && (cpu_wdata != cpu_status)) |=> $stable(cpu_status)); // R9

    AST_RST_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (req_n && !cfg_err && host_rdata == '0)); // R1

endmodule

// File: tb/sim_hostreq_ctrl.sv
module sim_hostreq_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sw_rst = 1'b0, port_rst = 1'b0, stop_rst = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_status;
    logic       rx_full = 1'b0, tx_empty = 1'b0;
    logic       req_n, cfg_err;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    hostreq_ctrl u0 (
        .clk(clk), .rst(rst), .sw_rst(sw_rst), .port_rst(port_rst), .stop_rst(stop_rst),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_status(cpu_status),
        .rx_full(rx_full), .tx_empty(tx_empty), .req_n(req_n), .cfg_err(cfg_err)
    );

    // {ctrl word, rx_full, tx_empty, expected req_n}
    localparam int NV = 15;
    localparam logic [10:0] VEC [NV] = '{
        {8'h00, 1'b1, 1'b1, 1'b1},
        {8'h01, 1'b1, 1'b0, 1'b0},
        {8'h01, 1'b0, 1'b1, 1'b1},
        {8'h02, 1'b0, 1'b1, 1'b0},
        {8'h02, 1'b1, 1'b0, 1'b1},
        {8'h03, 1'b1, 1'b0, 1'b0},
        {8'h03, 1'b0, 1'b1, 1'b0},
        {8'h03, 1'b0, 1'b0, 1'b1},
        {8'h19, 1'b1, 1'b0, 1'b0},
        {8'h20, 1'b1, 1'b1, 1'b1},
        {8'h21, 1'b1, 1'b0, 1'b0},
        {8'h21, 1'b0, 1'b1, 1'b1},
        {8'h42, 1'b0, 1'b1, 1'b0},
        {8'h62, 1'b1, 1'b0, 1'b1},
        {8'h7A, 1'b0, 1'b1, 1'b0}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic [7:0] v);
        @(negedge clk);
        host_wr    = 1'b1;
        host_wdata = v;
        @(negedge clk);
        host_wr    = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 rdata in reset", host_rdata, 8'h00);
        check("R1 req_n in reset", {7'b0, req_n}, 8'h01);
        rst = 1'b0;
        @(negedge clk);
        check("R1 rdata", host_rdata, 8'h00);
        check("R1 err", {7'b0, cfg_err}, 8'h00);
        check("R1 status", cpu_status, 8'h00);

        // table walk
        for (int i = 0; i < NV; i++) begin
            string tag;
            logic [7:0] w;
            w = VEC[i][10:3];
            tag = (i == 0) ? "R4" : (w[6:5] == 2'b00) ? "R5" : "R6";
            rx_full  = VEC[i][2];
            tx_empty = VEC[i][1];
            host_write(w);
            check("R2 readback", host_rdata, w & 8'h7B);
            @(negedge clk);
            check(tag, {7'b0, req_n}, {7'b0, VEC[i][0]});
            check("R11 mirror", cpu_status, w & 8'h18);
        end
        check("R7 no error after legal rows", {7'b0, cfg_err}, 8'h00);

        // reserved bits
        host_write(8'h84);
        check("R3 reserved bits", host_rdata, 8'h00);
        host_write(8'hFF & ~8'h60 | 8'h04);
        check("R3 reserved bit 2", host_rdata[2] | host_rdata[7], 1'b0);

        // registered request
        host_write(8'h02);
        tx_empty = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R8 idle", {7'b0, req_n}, 8'h01);
        tx_empty = 1'b1;
        #1;
        check("R8 same cycle", {7'b0, req_n}, 8'h01);
        @(negedge clk);
        check("R8 next edge", {7'b0, req_n}, 8'h00);

        // illegal DMA setting
        rx_full  = 1'b1;
        tx_empty = 1'b1;
        host_write(8'h23);
        @(negedge clk);
        check("R7 req held", {7'b0, req_n}, 8'h01);
        check("R7 err set", {7'b0, cfg_err}, 8'h01);
        host_write(8'h01);
        @(negedge clk);
        check("R7 legal again req", {7'b0, req_n}, 8'h00);
        check("R7 err sticky", {7'b0, cfg_err}, 8'h01);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 err cleared", {7'b0, cfg_err}, 8'h00);
        check("R1 ctrl cleared", host_rdata, 8'h00);

        // processor writes
        host_write(8'h18);
        @(negedge clk);
        cpu_wr = 1'b1;
        cpu_wdata = 8'h00;
        @(negedge clk);
        cpu_wr = 1'b0;
        check("R9 status kept", cpu_status, 8'h18);
        check("R9 flags kept", host_rdata, 8'h18);
        host_write(8'h00);
        cpu_wr = 1'b1;
        cpu_wdata = 8'hFF;
        @(negedge clk);
        cpu_wr = 1'b0;
        check("R9 status not set", cpu_status, 8'h00);
        check("R9 rdata not set", host_rdata, 8'h00);

        // soft resets
        for (int k = 0; k < 3; k++) begin
            host_write(8'h19);
            check("R11 status both flags", cpu_status, 8'h18);
            @(negedge clk);
            case (k)
                0: sw_rst = 1'b1;
                1: port_rst = 1'b1;
                default: stop_rst = 1'b1;
            endcase
            @(negedge clk);
            sw_rst = 1'b0; port_rst = 1'b0; stop_rst = 1'b0;
            check("R10 rdata", host_rdata, 8'h00);
            check("R10 status", cpu_status, 8'h00);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule